// File: doc/BRIEF.md
# Biresidue Single-Error Corrector for SAD Words

This block sits between two processing elements of a motion-estimation array. It takes a sum-of-absolute-differences word that may carry a single arithmetic error of plus or minus a power of two. Alongside the word it takes a syndrome pair: a 3-bit residue difference modulo 7 and a 4-bit residue difference modulo 15. From these it works out which bit was disturbed and in which direction, and repairs the word by subtracting or adding that power of two. The repaired word goes on to the next processing element.

Each of the 24 possible single errors (12 bit positions, two signs) produces a distinct syndrome pair. For a positive error at bit i the pair is (2^(i mod 3), 2^(i mod 4)). For a negative error it is (7 − 2^(i mod 3), 15 − 2^(i mod 4)). A pair of literal zeros means the word is clean. Any other pair is reported as uncorrectable, and the word then passes through untouched. All outputs are registered, with a single cycle of latency.

Top module: `bires_corrector`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid`, `out_fixed` and `out_uncorr` are 0 and `out_word` is 0.
- R2: `out_valid` equals `in_valid` from the preceding clock edge, so every accepted word yields exactly one result, one cycle later.
- R3: When the syndrome is exactly (s1=0, s2=0), the output word equals the input word and both `out_fixed` and `out_uncorr` are 0.
- R4: When (s1, s2) = (2^(i mod 3), 2^(i mod 4)) for some bit i in 0..11, the output is the input minus 2^i, `out_fixed` is 1 and `out_uncorr` is 0.
- R5: When (s1, s2) = (7 − 2^(i mod 3), 15 − 2^(i mod 4)) for some bit i in 0..11, the output is the input plus 2^i, `out_fixed` is 1 and `out_uncorr` is 0.
- R6: Any syndrome that is not (0,0) and not one of the 24 pairs of R4 and R5 sets `out_uncorr` to 1 and `out_fixed` to 0, and the word passes through unchanged. This includes pairs with s1 = 7 or s2 = 15.
- R7: `out_fixed` and `out_uncorr` are never 1 together.
- R8: The correction is taken modulo 2^12. An input of 0 with a positive bit-0 syndrome yields 4095, and an input of 4095 with a negative bit-0 syndrome yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and syndrome are valid |
| in_word | input | 12 | Possibly erroneous SAD word |
| in_s1 | input | 3 | Syndrome component modulo 7 |
| in_s2 | input | 4 | Syndrome component modulo 15 |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_word | output | 12 | Corrected or passed-through word |
| out_fixed | output | 1 | A single error was located and corrected |
| out_uncorr | output | 1 | The syndrome matched no single error |

## Verification
The two functions that can fall in the same cycle are the arithmetic repair of the word and the range wrap at the word's ends. They meet when an input of 0 carries a positive-error syndrome, or an input of 4095 carries a negative-error syndrome. The bench forces both corners for bit 0 and the top bit, and also applies every one of the 24 errors to random true values, some of which wrap. Each result is judged against a true value computed modulo 4096. In addition, all 128 syndrome pairs are swept to separate the repairable pairs from the uncorrectable ones.

// File: rtl/bires_pkg.sv
package bires_pkg;
  // residue of 2^i modulo (2^m - 1) is 2^(i mod m)
  function automatic int pow2_res(input int i, input int m);
    return 1 << (i % m);
  endfunction
endpackage

// File: rtl/bires_syn_decode.sv
module bires_syn_decode #(
  parameter int W      = 12,
  parameter int A_BITS = 3,
  parameter int B_BITS = 4
) (
  input  logic [A_BITS-1:0] s1,
  input  logic [B_BITS-1:0] s2,
  output logic [W-1:0]      pos_hit,
  output logic [W-1:0]      neg_hit,
  output logic              is_zero
);
  import bires_pkg::*;
  localparam int MOD_A = (1 << A_BITS) - 1;
  localparam int MOD_B = (1 << B_BITS) - 1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      localparam logic [A_BITS-1:0] PA = A_BITS'(pow2_res(i, A_BITS));
      localparam logic [B_BITS-1:0] PB = B_BITS'(pow2_res(i, B_BITS));
      localparam logic [A_BITS-1:0] NA = A_BITS'(MOD_A - pow2_res(i, A_BITS));
      localparam logic [B_BITS-1:0] NB = B_BITS'(MOD_B - pow2_res(i, B_BITS));
      assign pos_hit[i] = (s1 == PA) && (s2 == PB);
      assign neg_hit[i] = (s1 == NA) && (s2 == NB);
    end
  endgenerate

  assign is_zero = (s1 == '0) && (s2 == '0);
endmodule

// File: rtl/bires_fix.sv
module bires_fix #(
  parameter int W = 12
) (
  input  logic [W-1:0] word_in,
  input  logic [W-1:0] pos_hit,
  input  logic [W-1:0] neg_hit,
  input  logic         is_zero,
  output logic [W-1:0] word_out,
  output logic         fixed,
  output logic         uncorr
);
  logic any_hit;
  always_comb begin
    any_hit = (|pos_hit) || (|neg_hit);
    // one-hot hit vectors are themselves the magnitude of the error
    if (any_hit) word_out = word_in - pos_hit + neg_hit;
    else         word_out = word_in;
    fixed  = any_hit;
    uncorr = !any_hit && !is_zero;
  end
endmodule

// File: rtl/bires_corrector.sv
module bires_corrector #(
  parameter int W      = 12,
  parameter int A_BITS = 3,
  parameter int B_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      in_word,
  input  logic [A_BITS-1:0] in_s1,
  input  logic [B_BITS-1:0] in_s2,
  output logic              out_valid,
  output logic [W-1:0]      out_word,
  output logic              out_fixed,
  output logic              out_uncorr
);
  logic [W-1:0] pos_hit, neg_hit, fix_word;
  logic         is_zero, fix_ok, fix_bad;

  bires_syn_decode #(.W(W), .A_BITS(A_BITS), .B_BITS(B_BITS)) u_dec (
    .s1(in_s1), .s2(in_s2), .pos_hit(pos_hit), .neg_hit(neg_hit), .is_zero(is_zero)
  );

  bires_fix #(.W(W)) u_fix (
    .word_in(in_word), .pos_hit(pos_hit), .neg_hit(neg_hit), .is_zero(is_zero),
    .word_out(fix_word), .fixed(fix_ok), .uncorr(fix_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_fixed  <= 1'b0;
      out_uncorr <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word   <= fix_word;
        out_fixed  <= fix_ok;
        out_uncorr <= fix_bad;
      end else begin
        out_fixed  <= 1'b0;
        out_uncorr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bires_corrector_chk.sv
module bires_corrector_chk #(
  parameter int W      = 12,
  parameter int A_BITS = 3,
  parameter int B_BITS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [W-1:0]      in_word,
  input logic [A_BITS-1:0] in_s1,
  input logic [B_BITS-1:0] in_s2,
  input logic              out_valid,
  input logic [W-1:0]      out_word,
  input logic              out_fixed,
  input logic              out_uncorr
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_s1 == '0 && in_s2 == '0) |=>
      (out_word == $past(in_word) && !out_fixed && !out_uncorr));
  // R6
  uncorr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    out_uncorr |-> (out_word == $past(in_word)));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({out_fixed, out_uncorr}) <= 1);
  // R4
  fixed_changes_chk: assert property (@(posedge clk) disable iff (rst)
    out_fixed |-> (out_word != $past(in_word)));
endmodule

bind bires_corrector bires_corrector_chk #(.W(W), .A_BITS(A_BITS), .B_BITS(B_BITS)) u_chk (.*);

// File: tb/bires_corrector_tb_top.sv
module bires_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [11:0] in_word;
  logic [2:0]  in_s1;
  logic [3:0]  in_s2;
  logic        out_valid;
  logic [11:0] out_word;
  logic        out_fixed, out_uncorr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [11:0] w;
    logic        fx;
    logic        uc;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  bires_corrector dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_s1(in_s1), .in_s2(in_s2), .out_valid(out_valid), .out_word(out_word),
    .out_fixed(out_fixed), .out_uncorr(out_uncorr)
  );

  function automatic int s1_of(input int e);
    return ((e % 7) + 7) % 7;
  endfunction
  function automatic int s2_of(input int e);
    return ((e % 15) + 15) % 15;
  endfunction

  task automatic drive(input logic [11:0] w, input int s1, input int s2,
                       input logic [11:0] ew, input logic efx, input logic euc,
                       input string req);
    exp_t x;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_s1 = 3'(s1); in_s2 = 4'(s2);
    x.w = ew; x.fx = efx; x.uc = euc; x.req = req;
    sb.push_back(x);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compares results as they come out
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2: result with no pending item, actual word=%0d expected none", out_word);
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (out_word !== x.w || out_fixed !== x.fx || out_uncorr !== x.uc) begin
          errors++;
          $display("FAIL %s: actual word=%0d fixed=%0b uncorr=%0b expected word=%0d fixed=%0b uncorr=%0b",
                   x.req, out_word, out_fixed, out_uncorr, x.w, x.fx, x.uc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_word = '0; in_s1 = '0; in_s2 = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    checks++;
    if (out_valid !== 1'b0 || out_fixed !== 1'b0 || out_uncorr !== 1'b0 || out_word !== 12'd0) begin
      errors++;
      $display("FAIL R1: actual v=%0b f=%0b u=%0b w=%0d expected all 0",
               out_valid, out_fixed, out_uncorr, out_word);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual out_valid=%0b expected 0 after reset", out_valid);
    end

    // R3: clean words pass through
    for (int k = 0; k < 8; k++) begin
      logic [11:0] n;
      n = 12'($urandom);
      drive(n, 0, 0, n, 1'b0, 1'b0, "R3");
    end

    // R4 / R5: every single error applied to random true values
    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [11:0] n, np, nn;
        n  = 12'($urandom);
        np = n + 12'(1 << i);
        nn = n - 12'(1 << i);
        drive(np, s1_of(1 << i), s2_of(1 << i), n, 1'b1, 1'b0, "R4");
        drive(nn, s1_of(-(1 << i)), s2_of(-(1 << i)), n, 1'b1, 1'b0, "R5");
      end
    end

    // R2: gap cycles produce no result
    idle(); idle();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2: actual out_valid=%0b expected 0 after idle", out_valid);
    end

    // R8: wrap at the word ends
    drive(12'd0,    s1_of(1),  s2_of(1),  12'd4095, 1'b1, 1'b0, "R8");
    drive(12'd4095, s1_of(-1), s2_of(-1), 12'd0,    1'b1, 1'b0, "R8");
    drive(12'd1024, s1_of(2048),  s2_of(2048),  12'd3072, 1'b1, 1'b0, "R8");
    drive(12'd3072, s1_of(-2048), s2_of(-2048), 12'd1024, 1'b1, 1'b0, "R8");

    // R6: sweep every syndrome pair; unknown non-zero ones are uncorrectable
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 16; b++) begin
        bit known;
        logic [11:0] n;
        known = 0;
        for (int i = 0; i < 12; i++) begin
          if ((a == s1_of(1 << i) && b == s2_of(1 << i)) ||
              (a == s1_of(-(1 << i)) && b == s2_of(-(1 << i)))) known = 1;
        end
        n = 12'($urandom);
        if (!known && !(a == 0 && b == 0))
          drive(n, a, b, n, 1'b0, 1'b1, "R6");
      end
    end
    idle(); idle(); idle();

    // R2: every item produced a result
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: actual pending=%0d expected 0", sb.size());
    end
    // R7 is covered by each scoreboard comparison of both flags
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule